// File: doc/BRIEF.md
# Per-Core Interrupt Claim Controller

This block is the local interrupt interface of one processor core in a multi-core system. It keeps one enable flag and one in-service flag per interrupt number. Software turns an interrupt on or off by writing its number to a set port or a clear port, rather than by a read-modify-write of a mask. A read of the ready register returns the lowest-numbered interrupt that is pending, enabled and not already in service. That read also claims the interrupt. Writing the number back to the completion register ends its service and sends a completion strobe out toward the shared distributor.

Numbers below 32 are private to this core. Higher numbers arrive on a vector that a global router has already steered to this core. The block also drives inter-processor interrupts. A single signal-register write carries the interrupt number and a mask of destination cores, and the block turns it into one-cycle request pulses. A request aimed at this core arrives on its own input and sets a local pending flag on number 15.

Top module: `core_irq_claim`

## Requirements
- R1: After reset, `irq_o`, `cmpl_valid_o` and `ipi_req_o` are low, `reg_rdata_o` is 0, and all enable, in-service and inter-processor pending flags are clear. The local interface is disabled.
- R2: Bit 0 of the control register (offset 0x000) enables the local interface. A read of 0x000 returns that bit. `irq_o` is high exactly when the interface is enabled and at least one interrupt is ready.
- R3: Writing N (taken from write-data bits [9:0]) to offset 0x0A0 enables interrupt N, and writing N to offset 0x0A4 disables it. A value N of NUM_IRQ or more changes no flag.
- R4: A read of offset 0x06C places on `reg_rdata_o`, one cycle later, the lowest-numbered ready interrupt. An interrupt is ready when it is pending, enabled and not in service. The read returns 0x3FF when no interrupt is ready or the interface is disabled.
- R5: A ready-register read that returns a number marks that number as in service. From then on it is not presented, and it does not drive `irq_o`, until its completion.
- R6: Writing N to offset 0x0B4, with N below NUM_IRQ, clears the in-service flag of N. In the next cycle it also pulses `cmpl_valid_o` for one cycle with `cmpl_id_o` equal to N.
- R7: Interrupt 15 counts as pending when private line 15 is high or the local inter-processor pending flag is set. `ipi_set_i` sets the flag and a completion write of 15 clears it. When both happen in the same cycle, the set wins.
- R8: A write to offset 0x060 whose bits [3:0] equal 15 drives `ipi_req_o` with write-data bits [8+NUM_CORES-1:8] for exactly one cycle, in the next cycle. A write with any other number in bits [3:0] leaves `ipi_req_o` low.
- R9: Numbers 0 to 31 take their pending state from `pend_priv_i[N]`. Numbers from 32 up take it from `pend_route_i[N-32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_priv_i | input | PRIV_IRQ | Pending lines of the private numbers |
| pend_route_i | input | NUM_IRQ-PRIV_IRQ | Pending lines of the routed numbers |
| ipi_set_i | input | 1 | Inter-processor request aimed at this core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Byte offset in the local window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the core |
| cmpl_valid_o | output | 1 | Completion strobe |
| cmpl_id_o | output | 10 | Number carried by the completion strobe |
| ipi_req_o | output | NUM_CORES | Inter-processor request pulses, one bit per destination core |

## Verification
`irq_o` is combinational. It reflects a flag change in the cycle right after the register write that causes it, and it follows the pending inputs within the same cycle. Read data, completion strobes and inter-processor pulses all appear one clock after their request. The bench's reference model therefore advances its state on each rising edge from the inputs held during the cycle before that edge. It then compares every output 2 ns after the edge, while those inputs are still applied. Because a pulse-width error or a one-cycle slip shows up as a mismatch in some cycle, the bench checks every output in every cycle.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'h3FF;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_SIG   = 12'h060;
  localparam logic [11:0] OFS_READY = 12'h06C;
  localparam logic [11:0] OFS_SETEN = 12'h0A0;
  localparam logic [11:0] OFS_CLREN = 12'h0A4;
  localparam logic [11:0] OFS_DONE  = 12'h0B4;

  typedef struct packed {
    logic ctrl_wr;
    logic ctrl_rd;
    logic sig_wr;
    logic ready_rd;
    logic seten_wr;
    logic clren_wr;
    logic done_wr;
  } acc_t;
endpackage

// File: rtl/cic_flag_bank.sv
module cic_flag_bank #(
  parameter int NUM_IRQ = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_i,
  input  logic                    clr_i,
  input  logic [cic_pkg::ID_W-1:0] id_i,
  output logic [NUM_IRQ-1:0]      flag_o
);
  import cic_pkg::*;

  logic [NUM_IRQ-1:0] flag_q, flag_d;

  // One flag per number; a number outside the bank matches no flag.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flag
    logic hit;
    assign hit = (id_i == ID_W'(g));
    always_comb begin
      flag_d[g] = flag_q[g];
      if (set_i && hit)      flag_d[g] = 1'b1;
      else if (clr_i && hit) flag_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cic_pick.sv
module cic_pick #(
  parameter int NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]       ready_i,
  output logic                     any_o,
  output logic [cic_pkg::ID_W-1:0] id_o
);
  import cic_pkg::*;

  // Scan downward so the lowest set bit is the last to write id_o.
  always_comb begin
    any_o = 1'b0;
    id_o  = NONE_ID;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (ready_i[i]) begin
        any_o = 1'b1;
        id_o  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/cic_ipi.sv
module cic_ipi #(
  parameter int NUM_CORES = 4,
  parameter int IPI_NUM   = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sig_wr_i,
  input  logic [31:0]          sig_data_i,
  input  logic                 ipi_set_i,
  input  logic                 ipi_clr_i,
  output logic                 pend_o,
  output logic [NUM_CORES-1:0] req_o
);
  localparam int MASK_LSB = 8;

  logic                 pend_q, pend_d;
  logic [NUM_CORES-1:0] req_q, req_d;
  logic                 num_ok;

  assign num_ok = (sig_data_i[3:0] == 4'(IPI_NUM));

  always_comb begin
    req_d = '0;
    if (sig_wr_i && num_ok) req_d = sig_data_i[MASK_LSB +: NUM_CORES];
    pend_d = pend_q;
    if (ipi_clr_i) pend_d = 1'b0;
    if (ipi_set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= '0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;
endmodule

// File: rtl/core_irq_claim.sv
module core_irq_claim #(
  parameter int NUM_IRQ   = 64,
  parameter int PRIV_IRQ  = 32,
  parameter int NUM_CORES = 4,
  parameter int IPI_NUM   = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PRIV_IRQ-1:0]         pend_priv_i,
  input  logic [NUM_IRQ-PRIV_IRQ-1:0] pend_route_i,
  input  logic                        ipi_set_i,
  input  logic                        reg_wr_i,
  input  logic                        reg_rd_i,
  input  logic [11:0]                 reg_addr_i,
  input  logic [31:0]                 reg_wdata_i,
  output logic [31:0]                 reg_rdata_o,
  output logic                        irq_o,
  output logic                        cmpl_valid_o,
  output logic [9:0]                  cmpl_id_o,
  output logic [NUM_CORES-1:0]        ipi_req_o
);
  import cic_pkg::*;

  acc_t              acc;
  logic [ID_W-1:0]   wid;
  logic              wid_in_range;
  logic [NUM_IRQ-1:0] en_q, act_q, pend_all, ready_vec;
  logic              any_ready, ipi_pend, lcl_en_q, lcl_en_d, claim;
  logic [ID_W-1:0]   pick_id;
  logic [31:0]       rdata_d;
  logic              cmpl_v_d;
  logic [ID_W-1:0]   cmpl_id_d;

  // Access decode
  always_comb begin
    acc          = '0;
    acc.ctrl_wr  = reg_wr_i && (reg_addr_i == OFS_CTRL);
    acc.ctrl_rd  = reg_rd_i && (reg_addr_i == OFS_CTRL);
    acc.sig_wr   = reg_wr_i && (reg_addr_i == OFS_SIG);
    acc.ready_rd = reg_rd_i && (reg_addr_i == OFS_READY);
    acc.seten_wr = reg_wr_i && (reg_addr_i == OFS_SETEN);
    acc.clren_wr = reg_wr_i && (reg_addr_i == OFS_CLREN);
    acc.done_wr  = reg_wr_i && (reg_addr_i == OFS_DONE);
  end

  assign wid          = reg_wdata_i[ID_W-1:0];
  assign wid_in_range = (wid < ID_W'(NUM_IRQ));

  // Enable flags
  cic_flag_bank #(.NUM_IRQ(NUM_IRQ)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (acc.seten_wr),
    .clr_i  (acc.clren_wr),
    .id_i   (wid),
    .flag_o (en_q)
  );

  // In-service flags: set by a claim, cleared by a completion
  cic_flag_bank #(.NUM_IRQ(NUM_IRQ)) u_active (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (claim),
    .clr_i  (acc.done_wr),
    .id_i   (claim ? pick_id : wid),
    .flag_o (act_q)
  );

  cic_ipi #(.NUM_CORES(NUM_CORES), .IPI_NUM(IPI_NUM)) u_ipi (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_wr_i   (acc.sig_wr),
    .sig_data_i (reg_wdata_i),
    .ipi_set_i  (ipi_set_i),
    .ipi_clr_i  (acc.done_wr && (wid == ID_W'(IPI_NUM))),
    .pend_o     (ipi_pend),
    .req_o      (ipi_req_o)
  );

  // Pending vector: private lines below, routed lines above
  always_comb begin
    pend_all = {pend_route_i, pend_priv_i};
    pend_all[IPI_NUM] = pend_priv_i[IPI_NUM] | ipi_pend;
  end

  assign ready_vec = pend_all & en_q & ~act_q;

  cic_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .ready_i (ready_vec),
    .any_o   (any_ready),
    .id_o    (pick_id)
  );

  assign claim = acc.ready_rd && lcl_en_q && any_ready;
  assign irq_o = lcl_en_q && any_ready;

  // Next-state logic of the local registers
  always_comb begin
    lcl_en_d = acc.ctrl_wr ? reg_wdata_i[0] : lcl_en_q;

    rdata_d = reg_rdata_o;
    if (acc.ctrl_rd)       rdata_d = {31'b0, lcl_en_q};
    else if (acc.ready_rd) rdata_d = {22'b0, (claim ? pick_id : NONE_ID)};
    else if (reg_rd_i)     rdata_d = '0;

    cmpl_v_d  = acc.done_wr && wid_in_range;
    cmpl_id_d = cmpl_v_d ? wid : cmpl_id_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcl_en_q     <= 1'b0;
      reg_rdata_o  <= '0;
      cmpl_valid_o <= 1'b0;
      cmpl_id_o    <= '0;
    end else begin
      lcl_en_q     <= lcl_en_d;
      reg_rdata_o  <= rdata_d;
      cmpl_valid_o <= cmpl_v_d;
      cmpl_id_o    <= cmpl_id_d;
    end
  end
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CORES = 4,
  parameter int IPI_NUM   = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_o,
  input logic                 lcl_en_q,
  input logic                 claim,
  input logic [9:0]           pick_id,
  input logic [NUM_IRQ-1:0]   act_q,
  input logic                 cmpl_valid_o,
  input logic [NUM_CORES-1:0] ipi_req_o,
  input logic                 reg_wr_i,
  input logic [11:0]          reg_addr_i,
  input logic [31:0]          reg_wdata_i
);
  localparam int IXW = $clog2(NUM_IRQ);

  a_r2_irq_needs_local: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> lcl_en_q);

  a_r4_claim_only_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> irq_o);

  a_r5_claim_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> act_q[$past(pick_id[IXW-1:0])]);

  a_r6_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid_o |-> $past(reg_wr_i && (reg_addr_i == 12'h0B4)));

  a_r8_ipi_after_signal: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_req_o != '0) |-> $past(reg_wr_i && (reg_addr_i == 12'h060)
                                && (reg_wdata_i[3:0] == 4'(IPI_NUM))));
endmodule

bind core_irq_claim cic_checker #(
  .NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES), .IPI_NUM(IPI_NUM)
) u_cic_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_o        (irq_o),
  .lcl_en_q     (lcl_en_q),
  .claim        (claim),
  .pick_id      (pick_id),
  .act_q        (act_q),
  .cmpl_valid_o (cmpl_valid_o),
  .ipi_req_o    (ipi_req_o),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i)
);

// File: tb/test_core_irq_claim.sv
`timescale 1ns/1ps
module test_core_irq_claim;
  localparam int NIRQ = 64;
  localparam int NPRV = 32;
  localparam int NCOR = 4;
  localparam int NONE = 1023;

  logic clk, rst_n;
  logic [NPRV-1:0]      priv;
  logic [NIRQ-NPRV-1:0] route;
  logic ipi_set, wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic irq, cv;
  logic [9:0] cid;
  logic [NCOR-1:0] ireq;

  core_irq_claim i_core_irq_claim (
    .clk(clk), .rst_n(rst_n), .pend_priv_i(priv), .pend_route_i(route),
    .ipi_set_i(ipi_set), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .cmpl_valid_o(cv), .cmpl_id_o(cid), .ipi_req_o(ireq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model state
  bit m_en[NIRQ];
  bit m_act[NIRQ];
  bit m_ipi, m_lcl, m_cv;
  int m_rdata, m_cid, m_ireq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic bit m_pend(int i);
    if (i < NPRV) return priv[i] || (i == 15 && m_ipi);
    return route[i - NPRV];
  endfunction

  function automatic int m_pick();
    for (int i = 0; i < NIRQ; i++)
      if (m_en[i] && !m_act[i] && m_pend(i)) return i;
    return NONE;
  endfunction

  task automatic chk(string tag, string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "irq_o", int'(irq), int'(m_lcl && m_pick() != NONE));
    chk(tag, "reg_rdata_o", int'(rdata), m_rdata);
    chk(tag, "cmpl_valid_o", int'(cv), int'(m_cv));
    chk(tag, "cmpl_id_o", int'(cid), m_cid);
    chk(tag, "ipi_req_o", int'(ireq), m_ireq);
  endtask

  // One clock: inputs driven at the falling edge, model advanced over the rising edge
  task automatic step(bit w, bit r, int a, int d, bit s, string tag);
    int pk, n;
    @(negedge clk);
    wr = w; rd = r; addr = 12'(a); wdata = 32'(d); ipi_set = s;
    pk = m_pick();
    n  = d & 32'h3FF;
    m_cv = 0; m_ireq = 0;
    if (r) begin
      if (a == 'h000) m_rdata = int'(m_lcl);
      else if (a == 'h06C) begin
        if (m_lcl && pk != NONE) begin m_rdata = pk; m_act[pk] = 1; end
        else m_rdata = NONE;
      end else m_rdata = 0;
    end
    if (w) begin
      case (a)
        'h000: m_lcl = d[0];
        'h0A0: if (n < NIRQ) m_en[n] = 1;
        'h0A4: if (n < NIRQ) m_en[n] = 0;
        'h0B4: if (n < NIRQ) begin
                 m_act[n] = 0; m_cv = 1; m_cid = n;
                 if (n == 15) m_ipi = 0;
               end
        'h060: if ((d & 'hF) == 15) m_ireq = (d >> 8) & ((1 << NCOR) - 1);
        default: ;
      endcase
    end
    if (s) m_ipi = 1;
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  task automatic wreg(int a, int d, string tag); step(1, 0, a, d, 0, tag); endtask
  task automatic rreg(int a, string tag);        step(0, 1, a, 0, 0, tag); endtask
  task automatic idle(string tag);               step(0, 0, 0, 0, 0, tag); endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    priv = '0; route = '0; ipi_set = 0; wr = 0; rd = 0; addr = '0; wdata = '0;
    m_ipi = 0; m_lcl = 0; m_cv = 0; m_rdata = 0; m_cid = 0; m_ireq = 0;
    for (int i = 0; i < NIRQ; i++) begin m_en[i] = 0; m_act[i] = 0; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    compare("R1 reset");
    @(negedge clk) rst_n = 1;
    idle("R1 idle");

    // Pending but not enabled, interface off
    priv[3] = 1;
    rreg('h06C, "R4 none ready");
    // Local enable
    wreg('h000, 1, "R2 enable local");
    rreg('h000, "R2 read ctrl");
    wreg('h0A0, 3, "R3 set enable 3");
    rreg('h06C, "R4 R5 claim 3");
    rreg('h06C, "R5 no reclaim");
    idle("R5 irq low while active");
    wreg('h0B4, 3, "R6 complete 3");
    idle("R6 strobe gone");
    // Routed number
    route[8] = 1;
    wreg('h0A0, 40, "R9 enable 40");
    rreg('h06C, "R4 lowest wins");
    wreg('h0A4, 3, "R3 clear enable 3");
    wreg('h0B4, 3, "R6 complete 3 again");
    rreg('h06C, "R9 routed 40");
    wreg('h0B4, 40, "R6 complete 40");
    wreg('h0A4, 200, "R3 clear out of range ignored");
    idle("R3 40 still requests");
    wreg('h0B4, 200, "R6 out of range no strobe");
    // Disable local interface
    wreg('h000, 0, "R2 disable local");
    rreg('h06C, "R2 R4 read while off");
    rreg('h000, "R2 read ctrl off");
    wreg('h000, 1, "R2 re-enable");
    wreg('h0A4, 40, "R3 clear 40");
    // Inter-processor path
    wreg('h0A0, 15, "R7 enable 15");
    step(0, 0, 0, 0, 1, "R7 ipi arrives");
    idle("R7 pending held");
    rreg('h06C, "R7 claim 15");
    wreg('h0B4, 15, "R7 complete 15 clears");
    idle("R7 cleared");
    priv[15] = 1;
    idle("R7 private line 15");
    priv[15] = 0;
    step(1, 0, 'h0B4, 15, 1, "R7 set wins over clear");
    idle("R7 still pending");
    rreg('h06C, "R7 claim again");
    wreg('h0B4, 15, "R7 final complete");
    wreg('h060, 'h0A0F, "R8 signal mask A");
    idle("R8 one cycle");
    wreg('h060, 'h0F05, "R8 wrong number ignored");
    wreg('h060, 'h030F, "R8 signal mask 3");
    priv = '1;
    wreg('h0A0, 0, "R9 enable 0");
    rreg('h06C, "R4 claim 0");
    wreg('h0A0, 63, "R9 enable 63");
    route = '0; route[31] = 1; priv = '0;
    rreg('h06C, "R9 top number 63");
    idle("R5 all in service");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule